// File: doc/BRIEF.md
# Quantised First-Order-Hold DAC Interpolator

This block sits between a sampled control law and a 12-bit DAC. Each new control sample starts a ramp from the code that is on the DAC at that moment toward the new sample. The ramp is causal and lags the input by one sampling period. It is a staircase: the code changes only at the end of each sub-step, and every intermediate value is rounded toward minus infinity.

The sampling period is programmed as an integer count of base ticks, where one base tick is 1/128 s. The block sorts that count into one of seven power-of-two bands and picks a sub-step length of 2^s base ticks for the band. The number of sub-steps per period then comes from a plain right shift.

When a sample arrives, a short serial division splits the sample difference into a whole per-step increment and a remainder. During the ramp, an error accumulator adds the remainder on each step and carries against the step count. This produces exactly floor-rounded values with no multiplier.

Top module: `fohq_interp`

## Requirements
- R1: After reset the DAC output is 0 and the block holds that value. Base ticks have no effect until a sample arrives.
- R2: The period count N is first limited to the range 8 to 524288. The shift s is then the largest j in 1..6 with N >= 2^(12+j), or 0 if there is none. The step count is k = N >> s. Examples: N=3 gives s=0, k=8. N=14 gives k=14. N=8192 gives s=1, k=4096. N=40000 gives s=3, k=5000. Any N of 2^19 or more gives s=6, k=8192.
- R3: After completed step i (1..k), the output equals p + floor((c - p)·i / k), rounded toward minus infinity. Here p is the start value and c is the sample.
- R4: During a ramp, the output changes only on the base tick that completes a sub-step, which is every 2^s base ticks. On every other cycle the output is unchanged.
- R5: Once all k steps are done, the output equals the sample. It stays there through any number of further base ticks until the next sample.
- R6: A sample arriving during a ramp takes the present output as its start value and restarts the step count. The output does not jump when the sample is taken.
- R7: The output always lies between the start value and the sample of the current ramp, inclusive, so it never leaves 0..4095.
- R8: For the first 14 cycles after a sample is taken, the block ignores base ticks while it forms the per-step increment and remainder. The remainder is always smaller than k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per 1/128 s base tick |
| period_i | input | 20 | Sampling period in base ticks, read when a sample is taken |
| smp_valid_i | input | 1 | New sample strobe |
| smp_data_i | input | 12 | Unsigned sample code |
| dac_o | output | 12 | Registered DAC code |

## Verification
On every cycle, the assertions check the following: the output moves only on a sub-step-completing tick, it stays inside the bounds of the current ramp, it sits on the sample while holding, and the division remainder stays below the step count. Only the bench scenarios can show that the values are the exact floor-rounded staircase. They also show that the band and step count picked for a given period are right, including clamping at both ends and negative slopes. Finally, they show that a restart mid-ramp begins from the output seen at the pins.

// File: rtl/fohq_pkg.sv
package fohq_pkg;
    localparam int DATA_W   = 12;
    localparam int PERIOD_W = 20;
    localparam int KBITS    = 13;
    localparam int NBANDS   = 7;
    localparam int KW       = KBITS + 1;
    localparam int SW       = 3;
    localparam int TW       = NBANDS - 1;
    localparam int MIN_N    = 8;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_DIV  = 2'd1,
        ST_RAMP = 2'd2
    } fohq_state_e;
endpackage

// File: rtl/fohq_period_map.sv
module fohq_period_map #(
    parameter int PERIOD_W = fohq_pkg::PERIOD_W,
    parameter int KBITS    = fohq_pkg::KBITS,
    parameter int NBANDS   = fohq_pkg::NBANDS,
    parameter int MIN_N    = fohq_pkg::MIN_N,
    parameter int KW       = KBITS + 1,
    parameter int SW       = fohq_pkg::SW
) (
    input  logic [PERIOD_W-1:0] period_i,
    output logic [SW-1:0]       shift_o,
    output logic [KW-1:0]       steps_o
);
    localparam logic [PERIOD_W-1:0] LO_N = PERIOD_W'(MIN_N);
    localparam logic [PERIOD_W-1:0] HI_N = PERIOD_W'(1) << (KBITS + NBANDS - 1);

    logic [PERIOD_W-1:0] n_clamped;

    always_comb begin
        if (period_i < LO_N)      n_clamped = LO_N;
        else if (period_i > HI_N) n_clamped = HI_N;
        else                      n_clamped = period_i;

        shift_o = '0;
        for (int j = 1; j < NBANDS; j++) begin
            if (n_clamped >= (PERIOD_W'(1) << (KBITS + j - 1))) shift_o = SW'(j);
        end
        steps_o = KW'(n_clamped >> shift_o);
    end
endmodule

// File: rtl/fohq_divider.sv
module fohq_divider #(
    parameter int DATA_W = fohq_pkg::DATA_W,
    parameter int KW     = fohq_pkg::KW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [DATA_W-1:0] dvd_i,
    input  logic [KW-1:0]     dvs_i,
    output logic              done_o,
    output logic [DATA_W-1:0] quo_o,
    output logic [KW-1:0]     rem_o
);
    localparam int CW = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] quo;
        logic [KW-1:0]     rem;
        logic [KW-1:0]     dvs;
        logic [CW-1:0]     cnt;
        logic              done;
    } div_t;

    div_t d_d, d_q;
    logic [KW:0] trial;

    always_comb begin
        d_d      = d_q;
        d_d.done = 1'b0;
        trial    = {d_q.rem, d_q.quo[DATA_W-1]};
        if (start_i) begin
            d_d.quo = dvd_i;
            d_d.rem = '0;
            d_d.dvs = dvs_i;
            d_d.cnt = CW'(DATA_W);
        end else if (d_q.cnt != '0) begin
            if (trial >= {1'b0, d_q.dvs}) begin
                d_d.rem = KW'(trial - {1'b0, d_q.dvs});
                d_d.quo = {d_q.quo[DATA_W-2:0], 1'b1};
            end else begin
                d_d.rem = KW'(trial);
                d_d.quo = {d_q.quo[DATA_W-2:0], 1'b0};
            end
            d_d.cnt  = d_q.cnt - 1'b1;
            d_d.done = (d_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) d_q <= '0;
        else         d_q <= d_d;
    end

    assign done_o = d_q.done;
    assign quo_o  = d_q.quo;
    assign rem_o  = d_q.rem;

    p_rem_below_divisor_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        d_q.done |-> (d_q.rem < d_q.dvs));
endmodule

// File: rtl/fohq_stepper.sv
module fohq_stepper #(
    parameter int DATA_W = fohq_pkg::DATA_W,
    parameter int KW     = fohq_pkg::KW,
    parameter int SW     = fohq_pkg::SW,
    parameter int TW     = fohq_pkg::TW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic [SW-1:0]     shift_i,
    input  logic [KW-1:0]     steps_i,
    output logic              div_start_o,
    output logic [DATA_W-1:0] div_dvd_o,
    input  logic              div_done_i,
    input  logic [DATA_W-1:0] div_quo_i,
    input  logic [KW-1:0]     div_rem_i,
    output logic [DATA_W-1:0] dac_o
);
    import fohq_pkg::*;

    typedef struct packed {
        fohq_state_e       st;
        logic [DATA_W-1:0] dac;
        logic [DATA_W-1:0] prev;
        logic [DATA_W-1:0] cur;
        logic              neg;
        logic [SW-1:0]     sh;
        logic [KW-1:0]     k;
        logic [KW-1:0]     idx;
        logic [KW-1:0]     err;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] inc;
        logic [KW-1:0]     frac;
        logic [TW-1:0]     tcnt;
    } stp_t;

    stp_t s_d, s_q;
    logic [TW:0]       one_sh;
    logic [TW-1:0]     sub_last;
    logic [KW:0]       err_sum;
    logic [DATA_W-1:0] acc_nxt;
    logic [KW-1:0]     idx_nxt;
    logic [KW-1:0]     err_nxt;
    logic              carry;

    always_comb begin
        s_d         = s_q;
        div_start_o = 1'b0;
        div_dvd_o   = (smp_data_i >= s_q.dac) ? smp_data_i - s_q.dac
                                              : s_q.dac - smp_data_i;
        one_sh      = (TW+1)'(1) << s_q.sh;
        sub_last    = TW'(one_sh - (TW+1)'(1));
        err_sum     = {1'b0, s_q.err} + {1'b0, s_q.frac};
        carry       = (err_sum >= {1'b0, s_q.k});
        err_nxt     = carry ? KW'(err_sum - {1'b0, s_q.k}) : KW'(err_sum);
        acc_nxt     = s_q.acc + s_q.inc + DATA_W'(carry);
        idx_nxt     = s_q.idx + 1'b1;

        if (smp_valid_i) begin
            div_start_o = 1'b1;
            s_d.st   = ST_DIV;
            s_d.prev = s_q.dac;
            s_d.cur  = smp_data_i;
            s_d.neg  = (smp_data_i < s_q.dac);
            s_d.sh   = shift_i;
            s_d.k    = steps_i;
            s_d.idx  = '0;
            s_d.err  = '0;
            s_d.acc  = '0;
            s_d.tcnt = '0;
        end else begin
            case (s_q.st)
                ST_DIV: begin
                    if (div_done_i) begin
                        s_d.inc  = div_quo_i;
                        s_d.frac = div_rem_i;
                        s_d.st   = ST_RAMP;
                    end
                end
                ST_RAMP: begin
                    if (tick_i) begin
                        if (s_q.tcnt == sub_last) begin
                            s_d.tcnt = '0;
                            s_d.idx  = idx_nxt;
                            s_d.err  = err_nxt;
                            s_d.acc  = acc_nxt;
                            s_d.dac  = s_q.neg
                                ? s_q.prev - acc_nxt - DATA_W'(err_nxt != '0)
                                : s_q.prev + acc_nxt;
                            if (idx_nxt == s_q.k) s_d.st = ST_HOLD;
                        end else begin
                            s_d.tcnt = s_q.tcnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q    <= '0;
            s_q.st <= ST_HOLD;
        end else begin
            s_q <= s_d;
        end
    end

    assign dac_o = s_q.dac;

    p_move_on_tick_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i || s_q.st != ST_RAMP) |=> $stable(s_q.dac));

    p_hold_on_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == ST_HOLD) |-> (s_q.dac == s_q.cur));

    p_within_ramp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.neg ? (s_q.dac <= s_q.prev && s_q.dac >= s_q.cur)
                : (s_q.dac >= s_q.prev && s_q.dac <= s_q.cur));

    p_steps_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == ST_RAMP) |-> (s_q.k >= KW'(8) && s_q.idx < s_q.k));

    p_start_no_jump_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_valid_i |=> (s_q.prev == $past(s_q.dac)));
endmodule

// File: rtl/fohq_interp.sv
module fohq_interp #(
    parameter int DATA_W   = fohq_pkg::DATA_W,
    parameter int PERIOD_W = fohq_pkg::PERIOD_W,
    parameter int KBITS    = fohq_pkg::KBITS,
    parameter int NBANDS   = fohq_pkg::NBANDS,
    parameter int MIN_N    = fohq_pkg::MIN_N
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                smp_valid_i,
    input  logic [DATA_W-1:0]   smp_data_i,
    output logic [DATA_W-1:0]   dac_o
);
    localparam int KW = KBITS + 1;
    localparam int SW = $clog2(NBANDS);
    localparam int TW = NBANDS - 1;

    logic [SW-1:0]     shift;
    logic [KW-1:0]     steps;
    logic              div_start;
    logic [DATA_W-1:0] div_dvd;
    logic              div_done;
    logic [DATA_W-1:0] div_quo;
    logic [KW-1:0]     div_rem;

    fohq_period_map #(
        .PERIOD_W(PERIOD_W), .KBITS(KBITS), .NBANDS(NBANDS),
        .MIN_N(MIN_N), .KW(KW), .SW(SW)
    ) u_map (
        .period_i(period_i),
        .shift_o (shift),
        .steps_o (steps)
    );

    fohq_divider #(.DATA_W(DATA_W), .KW(KW)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(div_start),
        .dvd_i  (div_dvd),
        .dvs_i  (steps),
        .done_o (div_done),
        .quo_o  (div_quo),
        .rem_o  (div_rem)
    );

    fohq_stepper #(.DATA_W(DATA_W), .KW(KW), .SW(SW), .TW(TW)) u_step (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .smp_valid_i(smp_valid_i),
        .smp_data_i (smp_data_i),
        .shift_i    (shift),
        .steps_i    (steps),
        .div_start_o(div_start),
        .div_dvd_o  (div_dvd),
        .div_done_i (div_done),
        .div_quo_i  (div_quo),
        .div_rem_i  (div_rem),
        .dac_o      (dac_o)
    );
endmodule

// File: tb/test_fohq_interp.sv
module test_fohq_interp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [19:0] period = 20'd14;
    logic        valid = 1'b0;
    logic [11:0] data = '0;
    logic [11:0] dac;

    int checks = 0;
    int errors = 0;
    int model_out = 0;
    bit finished = 0;

    typedef struct {
        int    exp;
        string tag;
    } item_t;
    item_t exp_q[$];
    event  chk_ev;

    always #2.5 clk = ~clk;

    fohq_interp i_fohq_interp (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .period_i(period),
        .smp_valid_i(valid), .smp_data_i(data), .dac_o(dac)
    );

    function automatic int fdiv(int a, int b);
        if (a >= 0) return a / b;
        return -((-a + b - 1) / b);
    endfunction

    task automatic push(int e, string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
        -> chk_ev;
        #0;
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    // Drives a sample, then nticks base ticks, pushing the expected code after each.
    task automatic run_ramp(int n, int smp, int nticks, string tag);
        int nc, s, k, p, step;
        nc = (n < 8) ? 8 : ((n > 524288) ? 524288 : n);
        s = 0;
        for (int j = 1; j <= 6; j++) if (nc >= (1 << (12 + j))) s = j;
        k = nc >> s;
        p = model_out;
        @(negedge clk);
        period = 20'(n);
        data   = 12'(smp);
        valid  = 1'b1;
        @(negedge clk) valid = 1'b0;
        push(p, "R6");
        pulse_tick();
        push(p, "R8");
        repeat (16) @(negedge clk);
        for (int t = 1; t <= nticks; t++) begin
            pulse_tick();
            step = t >> s;
            if (step > k) step = k;
            model_out = p + fdiv((smp - p) * step, k);
            push(model_out, (step == k && (t >> s) > k) ? "R5" : tag);
        end
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                checks++;
                if (int'(dac) != it.exp) begin
                    errors++;
                    $display("FAIL %s: dac_o=%0d expected %0d", it.tag, dac, it.exp);
                end
            end
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push(0, "R1");
        pulse_tick();
        push(0, "R1");
        run_ramp(14, 1000, 16, "R3");       // R2 k=14, R3 rising, R5 hold
        run_ramp(10, 3, 12, "R3");          // R3 falling, floor toward minus infinity
        run_ramp(3, 4095, 10, "R2");        // R2 clamp to 8 steps
        run_ramp(40000, 0, 60, "R4");       // R4 sub-step of 8 ticks, stopped mid-ramp
        run_ramp(14, 2000, 16, "R6");       // R6 restart from present output
        run_ramp(1048575, 1900, 70, "R2");  // R2 top clamp: 64-tick sub-step, k=8192
        run_ramp(8192, 100, 8200, "R7");    // R2 s=1 k=4096, R7 full ramp, R5 hold
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule